// File: doc/BRIEF.md
# Rice-Golomb sample encoder

This block turns a stream of unsigned samples into variable-length Rice-Golomb codes, at one sample per clock. Each accepted sample is split at a fixed bit position into a quotient and a remainder. The code puts the remainder bits first. The quotient follows in unary form, as a run of ones closed by a single zero. The block does not pack codes together. Each code leaves as one zero-padded word of fixed width, and a second word carries the number of meaningful bits in it. A downstream packer can then join the codes into a dense bit stream.

The sample width, the code word width and the split position are separate elaboration-time parameters. When a quotient is too large for the code word, the block still emits an entry, but a truncated one. It also sets a sticky overflow flag. The code words and the lengths go into two small first-word-fall-through FIFOs that fill in step. If either FIFO is full when an entry is due, the entry is lost and a sticky exception flag is set.

Top module: `rg_encoder`

## Requirements
- R1: For a sample S, the quotient is Q = S >> DIV_BITS and the remainder is the low DIV_BITS bits of S. The remainder occupies code word bits [DIV_BITS-1:0] unchanged, with its least significant bit at bit 0.
- R2: When the code fits, bits DIV_BITS to DIV_BITS+Q-1 of the code word are ones. Bit DIV_BITS+Q is zero, and every bit above it is zero.
- R3: When the code fits, the length word equals DIV_BITS + 1 + Q. The code fits when that length is at most CODE_W.
- R4: When DIV_BITS + 1 + Q exceeds CODE_W, the entry is still written. Its remainder is in place, bits DIV_BITS to CODE_W-1 are ones, and the length word holds CODE_W. The overflow flag goes high and stays high until reset.
- R5: A cycle with in_valid low writes nothing to either FIFO, whatever value in_sample holds.
- R6: A sample accepted at clock edge t is written to both FIFOs at edge t+1. Entries leave the FIFOs in acceptance order, and the code and length at the two FIFO heads belong to the same sample.
- R7: If either FIFO is full when an entry is due, that entry is written to neither FIFO. The exception flag then goes high and stays high until reset. Entries that were already stored are not affected.
- R8: Synchronous active-high reset empties both FIFOs and clears both flags.
- R9: Each FIFO shows its head entry on its data output while it is not empty. A high read enable on a non-empty FIFO removes the head at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies in_sample in this cycle |
| in_sample | input | SAMPLE_W | Unsigned sample to encode |
| code_rd_en | input | 1 | Pop the code FIFO head |
| code_data | output | CODE_W | Code FIFO head: padded code word |
| code_empty | output | 1 | Code FIFO holds no entry |
| len_rd_en | input | 1 | Pop the length FIFO head |
| len_data | output | 32 | Length FIFO head: valid bit count |
| len_empty | output | 1 | Length FIFO holds no entry |
| ovf_flag | output | 1 | Sticky: some code did not fit in CODE_W |
| exc_flag | output | 1 | Sticky: an entry met a full FIFO |

## Verification
The assertions take for granted that the consumer pops both FIFOs in the same cycle, and only when they are not empty. Under that condition the two FIFOs hold the same number of entries. They also take for granted that DIV_BITS is below SAMPLE_W and that SAMPLE_W is at most 32, so a code length always fits in the length word. The stimulus drives code_rd_en and len_rd_en from one signal. That signal is high only while code_empty is low and draining is enabled. During the full-FIFO scenario draining is switched off, so the overrun comes from writes alone.

// File: rtl/rg_pkg.sv
package rg_pkg;

    localparam int LEN_W = 32;

    typedef logic [LEN_W-1:0] len_t;

    // Unclipped code size: remainder field, unary run, closing zero.
    function automatic len_t rg_raw_len(input int unsigned div_bits, input len_t quo);
        return len_t'(div_bits + 1) + quo;
    endfunction

    // Clip a code size to the output word width.
    function automatic len_t rg_clip_len(input len_t raw, input int unsigned word_w);
        return (raw > len_t'(word_w)) ? len_t'(word_w) : raw;
    endfunction

endpackage

// File: rtl/rg_code_gen.sv
module rg_code_gen
    import rg_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int CODE_W   = 32,
    parameter int DIV_BITS = 11
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [CODE_W-1:0]   word_o,
    output len_t                len_o,
    output logic                ovf_o
);
    localparam int QUO_W = SAMPLE_W - DIV_BITS;

    logic [QUO_W-1:0]    quo;
    logic [DIV_BITS-1:0] rem;
    len_t                quo_ext;
    len_t                raw_len;

    assign quo     = sample_i[SAMPLE_W-1:DIV_BITS];
    assign rem     = sample_i[DIV_BITS-1:0];
    assign quo_ext = len_t'(quo);
    assign raw_len = rg_raw_len(DIV_BITS, quo_ext);
    assign ovf_o   = raw_len > len_t'(CODE_W);
    assign len_o   = rg_clip_len(raw_len, CODE_W);

    // Per-bit layout: remainder low, then a thermometer of the quotient.
    for (genvar i = 0; i < CODE_W; i++) begin : g_bit
        if (i < DIV_BITS) begin : g_rem
            assign word_o[i] = rem[i];
        end else begin : g_unary
            localparam len_t POS = len_t'(i - DIV_BITS);
            assign word_o[i] = (POS < quo_ext);
        end
    end

endmodule

// File: rtl/rg_fifo.sv
module rg_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         full,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wr_ptr;
    logic [AW:0]  rd_ptr;
    logic         rd_fire;

    assign empty   = (wr_ptr == rd_ptr);
    assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign rd_fire = rd_en && !empty;
    assign rd_data = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_en && !full) begin
            mem[wr_ptr[AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en && !full) wr_ptr <= wr_ptr + 1'b1;
            if (rd_fire)        rd_ptr <= rd_ptr + 1'b1;
        end
    end

    AST_FIFO_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full) else $error("write into full FIFO"); // R7

    AST_FIFO_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_fire) |=> !empty) else $error("written entry not visible"); // R6

endmodule

// File: rtl/rg_encoder.sv
module rg_encoder
    import rg_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int CODE_W     = 32,
    parameter int DIV_BITS   = 11,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic                code_rd_en,
    output logic [CODE_W-1:0]   code_data,
    output logic                code_empty,
    input  logic                len_rd_en,
    output logic [LEN_W-1:0]    len_data,
    output logic                len_empty,
    output logic                ovf_flag,
    output logic                exc_flag
);
    typedef struct packed {
        logic              valid;
        logic              ovf;
        len_t              len;
        logic [CODE_W-1:0] word;
    } stage_t;

    logic [CODE_W-1:0] gen_word;
    len_t              gen_len;
    logic              gen_ovf;
    stage_t            stg;
    logic              code_full;
    logic              len_full;
    logic              push;

    rg_code_gen #(
        .SAMPLE_W (SAMPLE_W),
        .CODE_W   (CODE_W),
        .DIV_BITS (DIV_BITS)
    ) gen_i (
        .sample_i (in_sample),
        .word_o   (gen_word),
        .len_o    (gen_len),
        .ovf_o    (gen_ovf)
    );

    // One register stage between the encoder and the FIFO writes.
    always_ff @(posedge clk) begin
        if (rst) begin
            stg      <= '0;
            ovf_flag <= 1'b0;
        end else begin
            stg.valid <= in_valid;
            stg.ovf   <= in_valid && gen_ovf;
            stg.len   <= gen_len;
            stg.word  <= gen_word;
            if (in_valid && gen_ovf) ovf_flag <= 1'b1;
        end
    end

    // Both FIFOs take an entry or neither does, so they stay paired.
    assign push = stg.valid && !code_full && !len_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_flag <= 1'b0;
        end else if (stg.valid && (code_full || len_full)) begin
            exc_flag <= 1'b1;
        end
    end

    rg_fifo #(.W(CODE_W), .DEPTH(FIFO_DEPTH)) code_fifo_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (push),
        .wr_data (stg.word),
        .full    (code_full),
        .rd_en   (code_rd_en),
        .rd_data (code_data),
        .empty   (code_empty)
    );

    rg_fifo #(.W(LEN_W), .DEPTH(FIFO_DEPTH)) len_fifo_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (push),
        .wr_data (stg.len),
        .full    (len_full),
        .rd_en   (len_rd_en),
        .rd_data (len_data),
        .empty   (len_empty)
    );

    AST_LEN_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        stg.valid |-> (stg.len >= len_t'(DIV_BITS + 1)) && (stg.len <= len_t'(CODE_W)))
        else $error("length out of range"); // R3

    AST_UNARY_MATCHES_LEN: assert property (@(posedge clk) disable iff (rst)
        (stg.valid && !stg.ovf) |->
            (len_t'($countones(stg.word >> DIV_BITS)) == stg.len - len_t'(DIV_BITS + 1)))
        else $error("unary run disagrees with length"); // R2

    AST_OVF_FILLS_WORD: assert property (@(posedge clk) disable iff (rst)
        (stg.valid && stg.ovf) |->
            (len_t'($countones(stg.word >> DIV_BITS)) == len_t'(CODE_W - DIV_BITS)))
        else $error("overflowed code not filled"); // R4

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag) else $error("overflow flag cleared"); // R4

    AST_EXC_STICKY: assert property (@(posedge clk) disable iff (rst)
        exc_flag |=> exc_flag) else $error("exception flag cleared"); // R7

    AST_EXC_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(exc_flag) |-> $past(stg.valid)) else $error("exception without entry"); // R7

endmodule

// File: tb/rg_encoder_tb.sv
module rg_encoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int M     = 16;
    localparam int L     = 32;
    localparam int K     = 11;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [M-1:0]  in_sample = '0;
    logic          rd_en = 1'b0;
    logic [L-1:0]  code_data;
    logic          code_empty;
    logic [31:0]   len_data;
    logic          len_empty;
    logic          ovf_flag;
    logic          exc_flag;

    int n_checks = 0;
    int n_fails  = 0;
    bit drain_en = 1'b1;
    bit done     = 1'b0;

    logic [L-1:0] exp_word_q [$];
    logic [31:0]  exp_len_q  [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rg_encoder #(.SAMPLE_W(M), .CODE_W(L), .DIV_BITS(K), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .code_rd_en (rd_en),
        .code_data  (code_data),
        .code_empty (code_empty),
        .len_rd_en  (rd_en),
        .len_data   (len_data),
        .len_empty  (len_empty),
        .ovf_flag   (ovf_flag),
        .exc_flag   (exc_flag)
    );

    function automatic void model(input logic [M-1:0] s, output logic [L-1:0] w,
                                  output logic [31:0] n);
        int q;
        int len;
        q   = int'(s >> K);
        len = K + 1 + q;
        if (len > L) len = L;
        n = 32'(len);
        for (int i = 0; i < L; i++) begin
            if (i < K) w[i] = s[i];
            else       w[i] = ((i - K) < q);
        end
    endfunction

    task automatic check(input bit ok, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Driver: one sample per cycle; records what the scoreboard must see.
    task automatic send(input logic [M-1:0] s, input bit expect_kept);
        logic [L-1:0] w;
        logic [31:0]  n;
        @(posedge clk); #1;
        in_valid  = 1'b1;
        in_sample = s;
        if (expect_kept) begin
            model(s, w, n);
            exp_word_q.push_back(w);
            exp_len_q.push_back(n);
        end
    endtask

    task automatic idle(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk); #1;
            in_valid  = 1'b0;
            in_sample = M'(16'hBEEF ^ c);
        end
    endtask

    task automatic wait_drained();
        int t = 0;
        while ((exp_word_q.size() != 0 || !code_empty) && t < 500) begin
            @(posedge clk);
            t++;
        end
        @(negedge clk);
    endtask

    // Monitor: compares FIFO heads against the scoreboard and pops both.
    initial begin
        forever begin
            @(negedge clk);
            if (done) break;
            rd_en = 1'b0;
            if (!rst) begin
                if (code_empty != len_empty) begin
                    check(1'b0, "R6 FIFO pairing", 64'(code_empty), 64'(len_empty));
                end
                if (drain_en && !code_empty) begin
                    if (exp_word_q.size() == 0) begin
                        check(1'b0, "R5 R7 unexpected entry", 64'(code_data), 64'd0);
                    end else begin
                        logic [L-1:0] ew;
                        logic [31:0]  el;
                        ew = exp_word_q.pop_front();
                        el = exp_len_q.pop_front();
                        if (el == 32'(L) && (int'(el) < K + 1 + 63))
                            check(code_data == ew && len_data == el,
                                  "R1 R4 R6 R9 code/len", {code_data, len_data}, {ew, el});
                        else
                            check(code_data == ew && len_data == el,
                                  "R1 R2 R3 R6 R9 code/len", {code_data, len_data}, {ew, el});
                    end
                    rd_en = 1'b1;
                end
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        check(code_empty && len_empty, "R8 FIFOs empty after reset",
              64'({code_empty, len_empty}), 64'd3);
        check(!ovf_flag && !exc_flag, "R8 flags clear after reset",
              64'({ovf_flag, exc_flag}), 64'd0);

        // R5: idle cycles with junk on in_sample write nothing
        idle(6);
        @(negedge clk);
        check(code_empty && len_empty, "R5 no write without in_valid",
              64'({code_empty, len_empty}), 64'd3);

        // R1 R2 R3: fitting codes, including the exact-fit boundary (Q=20, len 32)
        send(16'h0000, 1'b1);
        send(16'h07FF, 1'b1);
        send(16'h0800, 1'b1);
        send(16'h0D55, 1'b1);
        send(M'((20 << K) | 5), 1'b1);
        send(16'h2AAA, 1'b1);
        idle(1);
        wait_drained();
        check(!ovf_flag, "R4 no overflow for fitting codes", 64'(ovf_flag), 64'd0);

        // R4: first code one bit too long (Q=21), then the largest sample
        send(M'((21 << K) | 11'h3C3), 1'b1);
        idle(2);
        @(negedge clk);
        check(ovf_flag, "R4 overflow flag set", 64'(ovf_flag), 64'd1);
        send(16'hFFFF, 1'b1);
        send(16'h0123, 1'b1);
        idle(1);
        wait_drained();
        check(ovf_flag, "R4 overflow flag sticky", 64'(ovf_flag), 64'd1);

        // Mixed stream with gaps
        lfsr = 16'hACE1;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send((i % 3 == 0) ? lfsr : (lfsr & 16'h3FFF), 1'b1);
            if (i % 7 == 6) idle(2);
        end
        idle(1);
        wait_drained();
        check(!exc_flag, "R7 no exception while draining", 64'(exc_flag), 64'd0);

        // R7: fill with draining stopped; entries five and six are lost
        drain_en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            send(M'(16'h0100 + i), i < DEPTH);
        end
        idle(3);
        @(negedge clk);
        check(exc_flag, "R7 exception on full FIFO", 64'(exc_flag), 64'd1);
        check(!code_empty && !len_empty, "R7 stored entries kept",
              64'({code_empty, len_empty}), 64'd0);
        drain_en = 1'b1;
        wait_drained();
        idle(3);
        @(negedge clk);
        check(code_empty && len_empty && exp_word_q.size() == 0,
              "R7 dropped entries absent", 64'({code_empty, len_empty}), 64'd3);
        check(exc_flag, "R7 exception flag sticky", 64'(exc_flag), 64'd1);

        // R8: reset clears flags and content
        send(16'h4444, 1'b0);
        @(posedge clk); #1;
        in_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check(!ovf_flag && !exc_flag && code_empty, "R8 reset clears state",
              64'({ovf_flag, exc_flag, code_empty}), 64'd1);

        finish_run();
    end

endmodule